// File: doc/BRIEF.md
# Wake Event Latch Unit

The unit watches up to 32 wake sources while the system sleeps. Each source passes through a synchronizer and then an edge detector. A per-source direction bit selects whether the detector looks for a rising or a falling transition. A detected transition sets a sticky bit in the raw event register. This happens whether the source is enabled or not. The bit stays set until software writes a 1 to it.

A separate enable register chooses which latched events may wake the system. The masked view of the events is the raw bits ANDed with the enables. A single wake line to the power controller is the OR of that view, registered once. The unit can share its sources with the interrupt controller, but its latches are independent of it.

Disabling a source also discards that source's pending event. When a clear and a fresh transition land in the same cycle, the fresh transition is kept. Clock and power sequencing are not part of this unit.

Top module: `wake_latch_unit`

## Requirements
- R1: After reset every enable bit is 0, every direction bit equals POL_RESET (default 0, falling edge), every raw event bit is 0, and `wake_o` is 0.
- R2: Register addresses are fixed. A write to address 0 replaces the enables and a write to address 1 replaces the direction bits. `rd_data_o` returns, combinationally, the enables at address 0, the direction bits at 1, the masked events at 2 and the raw events at 3.
- R3: With direction bit 1, a 0-to-1 transition of a source sets its raw bit, and a 1-to-0 transition does not.
- R4: With direction bit 0, a 1-to-0 transition of a source sets its raw bit, and a 0-to-1 transition does not.
- R5: A raw bit is set by its selected transition even while the source's enable bit is 0.
- R6: The value read at address 2 equals the raw events ANDed with the enables.
- R7: A write to address 3 clears each raw bit whose data bit is 1 and leaves the other raw bits unchanged. A write to address 2 changes no register.
- R8: If a clear of a raw bit (by address 3, or by disabling under R9) takes effect in the same cycle that a new selected transition of that source is detected, the bit stays set.
- R9: A write to address 0 that changes an enable bit from 1 to 0 also clears that source's raw bit.
- R10: `wake_o` is the OR of the masked events, delayed by one clock.
- R11: A source change driven before clock edge 1 appears in the raw bit after clock edge 3, and on `wake_o` after edge 4. The raw bit is not set after edge 2. A source held at a steady level sets nothing.
- R12: Changing a direction bit while its source is steady does not set the raw bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Wake sources, may be asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | NUM_SRC | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | NUM_SRC | Read data for rd_addr_i |
| wake_o | output | 1 | Registered wake request to the power controller |

## Verification
The hardest cases to reach are the collisions. In one, a clear write lands in exactly the cycle when a synchronized transition reaches the latch. In the other, an enable bit drops in that cycle. Both depend on the synchronizer delay. The bench therefore changes a source and counts two clock edges, so that the write is registered at the third edge, the same edge at which the latch takes the transition. It then repeats the clear one cycle later to show the contrast. A sweep over every source, both directions and both enable settings checks the latch latency edge by edge, and also checks that the opposite transition is ignored.

// File: rtl/wake_pkg.sv
package wake_pkg;

    // Register addresses seen on the write and read ports
    typedef enum logic [1:0] {
        ADDR_ENABLE   = 2'd0,
        ADDR_POLARITY = 2'd1,
        ADDR_MASKED   = 2'd2,
        ADDR_RAW      = 2'd3
    } wake_addr_e;

    localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
            end else begin
                stage_q[g] <= stage_d[g];
            end
        end
    end

    assign sync_o = stage_q[LAST];

endmodule

// File: rtl/wake_edge.sv
module wake_edge #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] pol_i,
    output logic [WIDTH-1:0] hit_o
);
    logic [WIDTH-1:0] prev_d;
    logic [WIDTH-1:0] prev_q;

    always_comb begin
        prev_d = level_i;
    end

    // A source hits when its level changed and the new level matches
    // the selected direction: 1 for rising, 0 for falling.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign hit_o[b] = (level_i[b] ^ prev_q[b]) & ~(level_i[b] ^ pol_i[b]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/wake_regs.sv
module wake_regs
    import wake_pkg::*;
#(
    parameter int unsigned          WIDTH     = 32,
    parameter logic [WIDTH-1:0]     POL_RESET = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic [WIDTH-1:0] hit_i,
    output logic [WIDTH-1:0] en_o,
    output logic [WIDTH-1:0] pol_o,
    output logic [WIDTH-1:0] raw_o,
    output logic             wake_o
);
    typedef struct packed {
        logic [WIDTH-1:0] en;
        logic [WIDTH-1:0] pol;
        logic [WIDTH-1:0] raw;
        logic             wake;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [WIDTH-1:0] clr_mask;

    always_comb begin
        st_d     = st_q;
        clr_mask = '0;

        if (wr_en_i) begin
            case (wake_addr_e'(wr_addr_i))
                ADDR_ENABLE: begin
                    st_d.en  = wr_data_i;
                    // sources being switched off drop their pending event
                    clr_mask = st_q.en & ~wr_data_i;
                end
                ADDR_POLARITY: begin
                    st_d.pol = wr_data_i;
                end
                ADDR_RAW: begin
                    clr_mask = wr_data_i;
                end
                default: begin
                    // masked view is read only
                end
            endcase
        end

        // a new transition overrides a clear in the same cycle
        st_d.raw  = (st_q.raw & ~clr_mask) | hit_i;
        st_d.wake = |(st_q.raw & st_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en   <= '0;
            st_q.pol  <= POL_RESET;
            st_q.raw  <= '0;
            st_q.wake <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign pol_o  = st_q.pol;
    assign raw_o  = st_q.raw;
    assign wake_o = st_q.wake;

endmodule

// File: rtl/wake_latch_unit.sv
module wake_latch_unit
    import wake_pkg::*;
#(
    parameter int unsigned          NUM_SRC     = 32,
    parameter int unsigned          SYNC_STAGES = 2,
    parameter logic [NUM_SRC-1:0]   POL_RESET   = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_addr_i,
    input  logic [NUM_SRC-1:0] wr_data_i,
    input  logic [1:0]         rd_addr_i,
    output logic [NUM_SRC-1:0] rd_data_o,
    output logic               wake_o
);
    localparam int unsigned STAGES =
        (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

    logic [NUM_SRC-1:0] src_sync;
    logic [NUM_SRC-1:0] edge_hit;
    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] pol_vec;
    logic [NUM_SRC-1:0] raw_vec;

    wake_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (src_sync)
    );

    wake_edge #(
        .WIDTH (NUM_SRC)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (src_sync),
        .pol_i   (pol_vec),
        .hit_o   (edge_hit)
    );

    wake_regs #(
        .WIDTH     (NUM_SRC),
        .POL_RESET (POL_RESET)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .hit_i     (edge_hit),
        .en_o      (en_vec),
        .pol_o     (pol_vec),
        .raw_o     (raw_vec),
        .wake_o    (wake_o)
    );

    always_comb begin
        case (wake_addr_e'(rd_addr_i))
            ADDR_ENABLE:   rd_data_o = en_vec;
            ADDR_POLARITY: rd_data_o = pol_vec;
            ADDR_MASKED:   rd_data_o = raw_vec & en_vec;
            default:       rd_data_o = raw_vec;
        endcase
    end

endmodule

// File: rtl/wake_latch_checker.sv
module wake_latch_checker
    import wake_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [1:0]         wr_addr,
    input logic [NUM_SRC-1:0] wr_data,
    input logic [NUM_SRC-1:0] edge_hit,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] raw_q,
    input logic               wake_o
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_q == '0 && raw_q == '0 && !wake_o));

    p_clear_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_RAW) |=>
            ((raw_q & $past(wr_data & ~edge_hit)) == '0));

    p_edge_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_hit) |=> ((raw_q & $past(edge_hit)) == $past(edge_hit)));

    p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_ENABLE) |=>
            ((raw_q & $past(en_q & ~wr_data & ~edge_hit)) == '0));

    p_wake_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (wake_o == $past(|(raw_q & en_q))));

    p_set_only_by_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(edge_hit)) == '0));

endmodule

bind wake_latch_unit wake_latch_checker #(
    .NUM_SRC (NUM_SRC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en_i),
    .wr_addr  (wr_addr_i),
    .wr_data  (wr_data_i),
    .edge_hit (edge_hit),
    .en_q     (en_vec),
    .raw_q    (raw_vec),
    .wake_o   (wake_o)
);

// File: tb/wake_latch_unit_tb.sv
module wake_latch_unit_tb;
    localparam int N = 4;
    localparam logic [1:0] A_EN = 2'd0, A_POL = 2'd1, A_MSK = 2'd2, A_RAW = 2'd3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic [1:0]   rd_addr = '0;
    logic [N-1:0] rd_data;
    logic         wake;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    wake_latch_unit #(.NUM_SRC(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .wake_o    (wake)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [N-1:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [N-1:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        rd(A_EN, v);  check("R1 enable", v, 0);
        rd(A_POL, v); check("R1 polarity", v, 0);
        rd(A_RAW, v); check("R1 raw", v, 0);
        check("R1 wake", wake, 0);
        // R11 steady level after reset sets nothing
        tick(6);
        rd(A_RAW, v); check("R11 steady", v, 0);

        // R2 readback
        wr(A_EN, 4'hA);  rd(A_EN, v);  check("R2 enable", v, 4'hA);
        wr(A_POL, 4'h5); rd(A_POL, v); check("R2 polarity", v, 4'h5);
        // R7 write to masked address ignored
        wr(A_MSK, 4'hF);
        rd(A_EN, v);  check("R7 msk ign en", v, 4'hA);
        rd(A_POL, v); check("R7 msk ign pol", v, 4'h5);
        rd(A_RAW, v); check("R7 msk ign raw", v, 0);
        wr(A_EN, 4'h0);

        // Sweep: every bit, both directions, both enables (R3 R4 R5 R6 R10 R11)
        for (int b = 0; b < N; b++) begin
            for (int p = 0; p < 2; p++) begin
                for (int e = 0; e < 2; e++) begin
                    logic [N-1:0] bm;
                    bm = N'(1) << b;
                    wr(A_EN, '0);
                    wr(A_POL, p ? bm : '0);
                    // move source to the inactive level, then clear
                    src[b] = (p == 0);
                    tick(6);
                    wr(A_RAW, '1);
                    wr(A_EN, e ? bm : '0);
                    tick(2);
                    rd(A_RAW, v); check("R11 quiet", v, 0);
                    // selected transition
                    src[b] = (p == 1);
                    tick(2);
                    rd(A_RAW, v); check("R11 not after edge 2", v, 0);
                    tick(1);
                    rd(A_RAW, v); check(p ? "R3 rise sets" : "R4 fall sets", v, bm);
                    if (!e) check("R5 latch while disabled", v, bm);
                    check("R10 wake lags", wake, 0);
                    rd(A_MSK, v); check("R6 masked", v, e ? bm : '0);
                    tick(1);
                    check("R10 wake", wake, e);
                    // opposite transition must not latch
                    wr(A_RAW, bm);
                    rd(A_RAW, v); check("R7 clear", v, 0);
                    src[b] = (p == 0);
                    tick(6);
                    rd(A_RAW, v); check(p ? "R3 fall ignored" : "R4 rise ignored", v, 0);
                    check("R10 wake idle", wake, 0);
                end
            end
        end

        // R12 direction change with steady source; all sources now 0 or 1
        wr(A_POL, '0);
        src = 4'b0011;
        tick(6);
        wr(A_RAW, '1);
        wr(A_POL, 4'hF);
        tick(5);
        wr(A_POL, 4'h0);
        tick(5);
        rd(A_RAW, v); check("R12 pol change", v, 0);

        // R7 selective clear: latch bits 2 and 3 (rising), clear only bit 2
        wr(A_POL, 4'hC);
        src = 4'b1111;
        tick(6);
        rd(A_RAW, v); check("R3 two bits", v, 4'hC);
        wr(A_RAW, 4'h4);
        rd(A_RAW, v); check("R7 selective", v, 4'h8);
        wr(A_RAW, 4'h3);
        rd(A_RAW, v); check("R7 zero bits kept", v, 4'h8);
        wr(A_RAW, '1);

        // R8 clear and new edge in same cycle (bit 0, falling)
        wr(A_POL, 4'h0);
        src[0] = 1'b0;
        tick(2);
        wr(A_RAW, 4'h1);
        rd(A_RAW, v); check("R8 edge beats clear", v, 4'h1);
        wr(A_RAW, 4'h1);
        rd(A_RAW, v); check("R7 later clear", v, 0);

        // R9 disable clears pending event
        wr(A_EN, 4'h2);
        src[1] = 1'b0;
        tick(6);
        rd(A_RAW, v); check("R9 pending", v, 4'h2);
        check("R10 wake set", wake, 1);
        wr(A_EN, 4'h0);
        rd(A_RAW, v); check("R9 disable clears", v, 0);
        tick(1);
        check("R10 wake dropped", wake, 0);

        // R8 disable in same cycle as new edge keeps the bit
        src[1] = 1'b1;
        tick(6);
        wr(A_EN, 4'h2);
        src[1] = 1'b0;
        tick(2);
        wr(A_EN, 4'h0);
        rd(A_RAW, v); check("R8 edge beats disable", v, 4'h2);

        tick(2);
        finish_run();
    end

endmodule